// File: doc/BRIEF.md
# Key-Panel Serial Slave with Display and Key Frames

This block is the host-facing port of a segment-display and key-matrix front-panel controller. A host talks to it over three wires: chip enable, a serial clock and a data-in line. A fourth data-out line is driven as an open-drain signal, where logic 1 means released. Every transfer starts with an address byte, clocked in while chip enable is low. Chip enable then rises, and the address byte decides what the data phase carries. Address 0x42 opens a write frame. The write frame carries one half of the 90 display bits, together with a small control word or an ignored control field. Address 0x43 opens a read frame, which returns 30 key bits and then a sleep-acknowledge bit. Any other address makes the block ignore the whole frame.

A write frame lands in the display latch and control register only when chip enable falls, and only if the frame had exactly the right length. A short or overlong frame is dropped. When no read is in progress and chip enable is low, data-out serves as an active-low key-request line for the key scanner. When a read frame completes, the block sends the scanner a one-cycle acknowledge. The chip reset pin blanks the display and holds data-out released. It does not stop transfers, so a host can load the display during reset.

All bus inputs are assumed to be synchronous to the system clock. The block finds the edges of the serial clock and chip enable by comparing each input with its value one cycle earlier.

Top module: `keypanel_serial_slave`

## Requirements
- R1: After power-on reset `porN`, the display output is all zero, all control outputs are zero, and `keyReadDone` is low.
- R2: An address byte is taken LSB first on serial-clock rising edges while chip enable is low. Address 0x42 then starts a 54-bit write frame, also taken LSB first on rising edges. Bits 0 to 44 are display bits. Bits 45 to 51 are control bits, in this order: sleep[0], sleep[1], keySel[0], keySel[1], portSel[0], portSel[1], blank. Bits 52 and 53 form a frame id, with bit 52 as the id LSB. A frame with id 0 loads display bits 0 to 44 and the control word.
- R3: A write frame with id 1 loads display bits 45 to 89. Its control field is ignored, and the control outputs keep their values.
- R4: A write frame is committed on the falling edge of chip enable, and only if exactly 54 data bits were clocked. A frame of 53 or 55 bits changes nothing, and neither does a frame with id 2 or 3.
- R5: A frame with an address other than 0x42 or 0x43 changes no display or control state and gives no acknowledge. While its chip enable is high, data-out stays released (1), even with a key request pending.
- R6: Address 0x43 takes a snapshot of {sleepAck, keyData} when chip enable rises. Data-out shows key bit 0 first. Each serial-clock falling edge advances one bit, and the 31st bit is sleepAck. A change of keyData during the read does not alter the bits returned.
- R7: `keyReadDone` pulses high for exactly one cycle after chip enable falls on a read frame of exactly 31 rising edges. A read frame of 30 or 32 edges gives no pulse.
- R8: With chip enable low and no read in progress, data-out equals the inverse of `keyReq`. While chip enable is high outside a read, data-out is 1.
- R9: While `resN` is low, the display output is zero and data-out is 1. Write frames received during reset are still committed and appear once `resN` rises.
- R10: When the blank control bit is 1, the display output is all zero. Clearing the blank bit restores the latched pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, clears all state |
| resN | input | 1 | Chip reset, active low; blanks display and releases data-out |
| busCe | input | 1 | Chip enable: low for the address phase, high for the data phase |
| busClk | input | 1 | Serial clock |
| busDi | input | 1 | Serial data in |
| busDoN | output | 1 | Serial data out / active-low key request (1 = released) |
| keyData | input | 30 | Key states from the scanner |
| sleepAck | input | 1 | Sleep-acknowledge flag from the scanner |
| keyReq | input | 1 | Key read request from the scanner |
| keyReadDone | output | 1 | One-cycle acknowledge after a complete read |
| dispData | output | 90 | Latched display bits, gated by reset and blank |
| sleepSel | output | 2 | Sleep control field |
| keySel | output | 2 | Key-scan / segment pin select field |
| portSel | output | 2 | Segment / general-purpose port select field |
| segBlank | output | 1 | Display blank control bit |

## Verification
The bench sends frames one bit short and one bit long, and frames with the unused id values 2 and 3. A design that commits on a count of at least 54 bits, or that ignores the id field, would corrupt the display or the control word. It checks that an id-1 frame leaves the control word unchanged, which catches a design that loads the control field on every frame. During a read it inverts keyData to catch a design that shifts live data instead of a snapshot, and it uses reads of 30 and 32 bits to catch a loose acknowledge count. It also writes during chip reset and watches data-out during foreign-address frames, which catches display leakage in reset and a request line that is not released.

// File: rtl/keypanel_serial_pkg.sv
package keypanel_serial_pkg;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_SKIP  = 2'd3
  } phase_t;

  // strobes from the control FSM to the datapath, each valid for one cycle
  typedef struct packed {
    logic addrShift;
    logic wrShift;
    logic rdLoad;
    logic rdShift;
    logic wrCommit;
  } strobe_t;

endpackage

// File: rtl/keypanel_serial_ctl.sv
module keypanel_serial_ctl
  import keypanel_serial_pkg::*;
#(
  parameter logic [7:0] ADDR_WR = 8'h42,
  parameter logic [7:0] ADDR_RD = 8'h43,
  parameter int WR_LEN = 54,
  parameter int RD_LEN = 31
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       busCe,
  input  logic       busClk,
  input  logic [7:0] addrByte,
  output strobe_t    strb,
  output logic       rdActive,
  output logic       keyReadDone
);

  localparam int CNT_MAX = WR_LEN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_WR   = CNT_W'(WR_LEN);
  localparam logic [CNT_W-1:0] CNT_RD   = CNT_W'(RD_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

  logic ceQ, clkQ;
  logic ceRise, ceFall, sclkRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  phase_t phase, nextData;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ceQ  <= 1'b0;
      clkQ <= 1'b0;
    end else begin
      ceQ  <= busCe;
      clkQ <= busClk;
    end
  end

  assign ceRise   = busCe & ~ceQ;
  assign ceFall   = ~busCe & ceQ;
  assign sclkRise = busClk & ~clkQ;
  assign sclkFall = ~busClk & clkQ;

  // decode of the captured address at the start of the data phase
  always_comb begin
    nextData = PH_SKIP;
    if (bitCnt == CNT_ADDR) begin
      if (addrByte == ADDR_WR)      nextData = PH_WRITE;
      else if (addrByte == ADDR_RD) nextData = PH_READ;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phase       <= PH_ADDR;
      bitCnt      <= '0;
      keyReadDone <= 1'b0;
    end else begin
      keyReadDone <= ceFall && (phase == PH_READ) && (bitCnt == CNT_RD);
      if (ceRise) begin
        phase  <= nextData;
        bitCnt <= '0;
      end else if (ceFall) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
      end else if (sclkRise && bitCnt != CNT_SAT) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.addrShift = sclkRise & ~busCe & ~ceQ;
    strb.wrShift   = sclkRise & busCe & ceQ & (phase == PH_WRITE);
    strb.rdLoad    = ceRise & (nextData == PH_READ);
    strb.rdShift   = sclkFall & busCe & ceQ & (phase == PH_READ);
    strb.wrCommit  = ceFall & (phase == PH_WRITE) & (bitCnt == CNT_WR);
  end

  assign rdActive = (phase == PH_READ);

endmodule

// File: rtl/keypanel_serial_dp.sv
module keypanel_serial_dp
  import keypanel_serial_pkg::*;
#(
  parameter int DISP_BITS = 90,
  parameter int KEY_BITS  = 30,
  parameter int CTRL_BITS = 7
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 resN,
  input  logic                 busCe,
  input  logic                 busDi,
  input  strobe_t              strb,
  input  logic                 rdActive,
  input  logic [KEY_BITS-1:0]  keyData,
  input  logic                 sleepAck,
  input  logic                 keyReq,
  output logic [7:0]           addrByte,
  output logic                 busDoN,
  output logic [DISP_BITS-1:0] dispData,
  output logic [1:0]           sleepSel,
  output logic [1:0]           keySel,
  output logic [1:0]           portSel,
  output logic                 segBlank
);

  localparam int HALF   = DISP_BITS / 2;
  localparam int WR_LEN = HALF + CTRL_BITS + 2;
  localparam int RD_LEN = KEY_BITS + 1;

  logic [WR_LEN-1:0]    wrSr;
  logic [RD_LEN-1:0]    rdSr;
  logic [CTRL_BITS-1:0] ctrlReg;
  logic [DISP_BITS-1:0] dispAll;
  logic [1:0]           frameId;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      addrByte <= '0;
      wrSr     <= '0;
      rdSr     <= '1;
    end else begin
      if (strb.addrShift) addrByte <= {busDi, addrByte[7:1]};
      if (strb.wrShift)   wrSr     <= {busDi, wrSr[WR_LEN-1:1]};
      if (strb.rdLoad)
        rdSr <= resN ? {sleepAck, keyData} : '0;
      else if (strb.rdShift)
        rdSr <= {1'b1, rdSr[RD_LEN-1:1]};
    end
  end

  assign frameId = {wrSr[WR_LEN-1], wrSr[WR_LEN-2]};

  // one latch per display half, selected by the frame id
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0] halfReg;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)
        halfReg <= '0;
      else if (strb.wrCommit && frameId == 2'(h))
        halfReg <= wrSr[HALF-1:0];
    end
    assign dispAll[h*HALF +: HALF] = halfReg;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)
      ctrlReg <= '0;
    else if (strb.wrCommit && frameId == 2'd0)
      ctrlReg <= wrSr[HALF +: CTRL_BITS];
  end

  assign sleepSel = ctrlReg[1:0];
  assign keySel   = ctrlReg[3:2];
  assign portSel  = ctrlReg[5:4];
  assign segBlank = ctrlReg[6];

  assign dispData = (resN && !segBlank) ? dispAll : '0;

  always_comb begin
    if (!resN)         busDoN = 1'b1;
    else if (rdActive) busDoN = rdSr[0];
    else if (busCe)    busDoN = 1'b1;
    else               busDoN = ~keyReq;
  end

endmodule

// File: rtl/keypanel_serial_slave.sv
module keypanel_serial_slave
  import keypanel_serial_pkg::*;
#(
  parameter int DISP_BITS = 90,
  parameter int KEY_BITS  = 30,
  parameter int CTRL_BITS = 7,
  parameter logic [7:0] ADDR_WR = 8'h42,
  parameter logic [7:0] ADDR_RD = 8'h43
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 resN,
  input  logic                 busCe,
  input  logic                 busClk,
  input  logic                 busDi,
  output logic                 busDoN,
  input  logic [KEY_BITS-1:0]  keyData,
  input  logic                 sleepAck,
  input  logic                 keyReq,
  output logic                 keyReadDone,
  output logic [DISP_BITS-1:0] dispData,
  output logic [1:0]           sleepSel,
  output logic [1:0]           keySel,
  output logic [1:0]           portSel,
  output logic                 segBlank
);

  localparam int WR_LEN = DISP_BITS / 2 + CTRL_BITS + 2;
  localparam int RD_LEN = KEY_BITS + 1;

  strobe_t    strb;
  logic       rdActive;
  logic [7:0] addrByte;

  keypanel_serial_ctl #(
    .ADDR_WR(ADDR_WR), .ADDR_RD(ADDR_RD), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN)
  ) u_ctl (
    .clk(clk), .porN(porN), .busCe(busCe), .busClk(busClk),
    .addrByte(addrByte), .strb(strb), .rdActive(rdActive),
    .keyReadDone(keyReadDone)
  );

  keypanel_serial_dp #(
    .DISP_BITS(DISP_BITS), .KEY_BITS(KEY_BITS), .CTRL_BITS(CTRL_BITS)
  ) u_dp (
    .clk(clk), .porN(porN), .resN(resN), .busCe(busCe), .busDi(busDi),
    .strb(strb), .rdActive(rdActive), .keyData(keyData),
    .sleepAck(sleepAck), .keyReq(keyReq), .addrByte(addrByte),
    .busDoN(busDoN), .dispData(dispData), .sleepSel(sleepSel),
    .keySel(keySel), .portSel(portSel), .segBlank(segBlank)
  );

endmodule

// File: rtl/keypanel_serial_chk.sv
module keypanel_serial_chk #(
  parameter int DISP_BITS = 90
) (
  input logic                 clk,
  input logic                 porN,
  input logic                 resN,
  input logic                 busCe,
  input logic                 busDoN,
  input logic                 keyReq,
  input logic                 keyReadDone,
  input logic [DISP_BITS-1:0] dispData,
  input logic [1:0]           sleepSel,
  input logic [1:0]           keySel,
  input logic [1:0]           portSel,
  input logic                 segBlank
);

  logic [6:0] ctrlVec;
  assign ctrlVec = {segBlank, portSel, keySel, sleepSel};

  a_r9_reset_blank: assert property (@(posedge clk) disable iff (!porN)
    !resN |-> dispData == '0);

  a_r9_reset_release: assert property (@(posedge clk) disable iff (!porN)
    !resN |-> busDoN);

  a_r10_blank_dark: assert property (@(posedge clk) disable iff (!porN)
    segBlank |-> dispData == '0);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!porN)
    keyReadDone |=> !keyReadDone);

  a_r7_done_after_ce_low: assert property (@(posedge clk) disable iff (!porN)
    keyReadDone |-> !$past(busCe));

  a_r8_idle_request: assert property (@(posedge clk) disable iff (!porN)
    (!busCe && !$past(busCe) && resN) |-> busDoN == !keyReq);

  a_r4_ctrl_hold_in_frame: assert property (@(posedge clk) disable iff (!porN)
    (busCe && $past(busCe)) |-> $stable(ctrlVec));

endmodule

bind keypanel_serial_slave keypanel_serial_chk #(.DISP_BITS(DISP_BITS)) u_chk (
  .clk(clk), .porN(porN), .resN(resN), .busCe(busCe), .busDoN(busDoN),
  .keyReq(keyReq), .keyReadDone(keyReadDone), .dispData(dispData),
  .sleepSel(sleepSel), .keySel(keySel), .portSel(portSel),
  .segBlank(segBlank)
);

// File: tb/keypanel_serial_slave_tb.sv
module keypanel_serial_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 45;
  localparam int WR_LEN = 54;
  localparam int RD_LEN = 31;

  logic clk = 1'b0;
  logic porN, resN, busCe, busClk, busDi, busDoN;
  logic [29:0] keyData;
  logic sleepAck, keyReq, keyReadDone;
  logic [89:0] dispData;
  logic [1:0] sleepSel, keySel, portSel;
  logic segBlank;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  bit finished = 1'b0;

  logic [HALF-1:0] loM, hiM;
  logic [6:0] ctrlM;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypanel_serial_slave u_dut (
    .clk(clk), .porN(porN), .resN(resN), .busCe(busCe), .busClk(busClk),
    .busDi(busDi), .busDoN(busDoN), .keyData(keyData), .sleepAck(sleepAck),
    .keyReq(keyReq), .keyReadDone(keyReadDone), .dispData(dispData),
    .sleepSel(sleepSel), .keySel(keySel), .portSel(portSel),
    .segBlank(segBlank)
  );

  always @(posedge clk) if (keyReadDone) doneCnt <= doneCnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [89:0] expDisp();
    return ctrlM[6] ? 90'd0 : {hiM, loM};
  endfunction

  task automatic checkState(input string req);
    chk(dispData == expDisp(), req, 96'(dispData), 96'(expDisp()));
    chk({segBlank, portSel, keySel, sleepSel} == ctrlM, req,
        96'({segBlank, portSel, keySel, sleepSel}), 96'(ctrlM));
  endtask

  task automatic pulseBit(input logic b);
    busDi = b; tick(2);
    busClk = 1'b1; tick(2);
    busClk = 1'b0; tick(2);
  endtask

  task automatic sendAddr(input logic [7:0] a);
    for (int i = 0; i < 8; i++) pulseBit(a[i]);
    busCe = 1'b1; tick(2);
  endtask

  task automatic endFrame();
    busCe = 1'b0; tick(3);
  endtask

  task automatic writeFrame(input logic [7:0] addr, input logic [HALF-1:0] d,
                            input logic [6:0] c, input logic [1:0] id,
                            input int len);
    logic [WR_LEN-1:0] fr;
    fr = {id, c, d};
    sendAddr(addr);
    for (int i = 0; i < len; i++) pulseBit(i < WR_LEN ? fr[i] : 1'b0);
    endFrame();
    if (addr == 8'h42 && len == WR_LEN) begin
      if (id == 2'd0) begin loM = d; ctrlM = c; end
      else if (id == 2'd1) hiM = d;
    end
  endtask

  task automatic readFrame(input int n, input bit disturb,
                           output logic [31:0] got);
    got = '1;
    sendAddr(8'h43);
    for (int i = 0; i < n; i++) begin
      if (i < 32) got[i] = busDoN;
      busClk = 1'b1; tick(2);
      if (disturb) keyData = ~keyData;
      busClk = 1'b0; tick(2);
    end
    endFrame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [29:0] kd;
    int d0;
    void'($urandom(32'd2024));
    porN = 1'b0; resN = 1'b1; busCe = 1'b0; busClk = 1'b0; busDi = 1'b0;
    keyData = '0; sleepAck = 1'b0; keyReq = 1'b0;
    loM = '0; hiM = '0; ctrlM = '0;
    tick(3); porN = 1'b1; tick(2);

    // R1 reset state
    checkState("R1");
    chk(keyReadDone == 1'b0, "R1", 96'(keyReadDone), 96'd0);
    chk(busDoN == 1'b1, "R1", 96'(busDoN), 96'd1);

    // R8 request line and release
    keyReq = 1'b1; tick(1);
    chk(busDoN == 1'b0, "R8", 96'(busDoN), 96'd0);
    busCe = 1'b1; tick(2);
    chk(busDoN == 1'b1, "R8", 96'(busDoN), 96'd1);
    busCe = 1'b0; tick(2); keyReq = 1'b0; tick(1);

    // R2 low half and control
    writeFrame(8'h42, 45'h1A2B_3C4D_5E6F & {HALF{1'b1}}, 7'b0110101, 2'd0, WR_LEN);
    checkState("R2");
    // R3 high half, control field ignored
    writeFrame(8'h42, 45'h0F0F_1234_ABCD, 7'b1001010, 2'd1, WR_LEN);
    checkState("R3");

    // R4 wrong lengths and ids
    writeFrame(8'h42, 45'h1555_5555_5555, 7'b1111111, 2'd0, WR_LEN - 1);
    checkState("R4");
    writeFrame(8'h42, 45'h0AAA_AAAA_AAAA, 7'b1111111, 2'd1, WR_LEN + 1);
    checkState("R4");
    writeFrame(8'h42, 45'h1FFF_FFFF_FFFF, 7'b1111111, 2'd2, WR_LEN);
    checkState("R4");
    writeFrame(8'h42, 45'h1FFF_FFFF_FFFF, 7'b1111111, 2'd3, WR_LEN);
    checkState("R4");

    // R5 foreign address
    d0 = doneCnt;
    keyReq = 1'b1;
    sendAddr(8'h55);
    chk(busDoN == 1'b1, "R5", 96'(busDoN), 96'd1);
    for (int i = 0; i < WR_LEN; i++) pulseBit(1'b1);
    chk(busDoN == 1'b1, "R5", 96'(busDoN), 96'd1);
    endFrame();
    keyReq = 1'b0;
    writeFrame(8'h44, 45'h1FFF_FFFF_FFFF, 7'b1111111, 2'd0, WR_LEN);
    checkState("R5");
    chk(doneCnt == d0, "R5", 96'(doneCnt), 96'(d0));

    // R6 read with snapshot, R7 acknowledge
    kd = 30'h2C3A_5F17; keyData = kd; sleepAck = 1'b1;
    d0 = doneCnt;
    readFrame(RD_LEN, 1'b1, got);
    chk(got[30:0] == {1'b1, kd}, "R6", 96'(got[30:0]), 96'({1'b1, kd}));
    chk(doneCnt == d0 + 1, "R7", 96'(doneCnt), 96'(d0 + 1));
    d0 = doneCnt;
    readFrame(RD_LEN - 1, 1'b0, got);
    chk(doneCnt == d0, "R7", 96'(doneCnt), 96'(d0));
    readFrame(RD_LEN + 1, 1'b0, got);
    chk(doneCnt == d0, "R7", 96'(doneCnt), 96'(d0));

    // R10 blank then restore
    writeFrame(8'h42, loM, 7'b1000011, 2'd0, WR_LEN);
    chk(dispData == 90'd0 && segBlank, "R10", 96'(dispData), 96'd0);
    writeFrame(8'h42, loM, 7'b0000011, 2'd0, WR_LEN);
    checkState("R10");

    // R9 chip reset: dark display, released line, writes still land
    resN = 1'b0; keyReq = 1'b1; tick(1);
    chk(dispData == 90'd0, "R9", 96'(dispData), 96'd0);
    chk(busDoN == 1'b1, "R9", 96'(busDoN), 96'd1);
    writeFrame(8'h42, 45'h0123_4567_89AB, 7'b0010100, 2'd0, WR_LEN);
    readFrame(RD_LEN, 1'b0, got);
    chk(got[30:0] == '1, "R9", 96'(got[30:0]), 96'h7FFF_FFFF);
    chk(dispData == 90'd0, "R9", 96'(dispData), 96'd0);
    resN = 1'b1; keyReq = 1'b0; tick(1);
    checkState("R9");

    // random mix of frames
    for (int it = 0; it < 24; it++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 6) begin
        int len;
        logic [1:0] id;
        len = (sel == 0) ? WR_LEN - 1 : (sel == 1) ? WR_LEN + 1 : WR_LEN;
        id = 2'($urandom_range(0, 3));
        writeFrame((sel == 5) ? 8'h40 : 8'h42,
                   {13'($urandom), $urandom}, 7'($urandom) & 7'h3F,
                   id, len);
        checkState(sel == 5 ? "R5" : (len != WR_LEN || id > 1) ? "R4" :
                   (id == 0) ? "R2" : "R3");
      end else begin
        kd = 30'($urandom); keyData = kd;
        sleepAck = 1'($urandom);
        d0 = doneCnt;
        readFrame(RD_LEN, 1'b1, got);
        chk(got[30:0] == {sleepAck, kd}, "R6", 96'(got[30:0]),
            96'({sleepAck, kd}));
        chk(doneCnt == d0 + 1, "R7", 96'(doneCnt), 96'(d0 + 1));
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule